// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block stores a stream of packed 32-bit trace words in an on-chip ring of RAM. Once capture is enabled, every valid word goes to the location named by a write pointer, and the pointer wraps at the end of the RAM. The ring therefore always holds the most recent words. When a trigger pulse arrives, a software-loaded down-counter starts counting the words that follow it. When the counter runs out, acquisition ends and the buffer freezes.

Software reaches the block through a small register file with single-cycle read and write strobes. Through it software can do the following:
- program the post-trigger count and the write pointer, and start or stop capture;
- poll a status word with four flags: wrapped, triggered, complete and pipeline empty;
- drain the RAM by placing a read pointer and reading a data register repeatedly. Each such read returns one word and advances the pointer.

The wrapped flag tells software where the oldest word sits. If it is set, the oldest word is at the write pointer. If it is clear, the valid words run from address 0 up to the write pointer minus one.

Top module: `trace_ring_capture`

Register addresses (reg_addr): 0 control, 1 status, 2 write pointer, 3 read pointer, 4 RAM data, 5 post-trigger counter, 6 depth, 7 word width. Any other address reads as 0. Read data appears on reg_rdata after the clock edge that samples reg_rd, and it holds until the next read.

## Requirements
- R1: After reset the following registers read 0: control, write pointer, read pointer and post-trigger counter. Status reads 0x8, meaning only the pipeline-empty flag is set.
- R2: The depth register (address 6) reads DEPTH, and the width register (address 7) reads WORD_W (32).
- R3: While control bit 0 is 1, each word with trc_vld high is written to RAM at the write pointer one cycle later. The pointer then advances by one and wraps from DEPTH-1 to 0. With control bit 0 at 0, words are not stored and the pointer does not move.
- R4: Status bit 0 (wrapped) sets when a RAM write occurs at address DEPTH-1. It stays set until capture is re-armed.
- R5: Status bit 1 (triggered) sets on a trig_in pulse while control bit 0 is 1. A trigger while capture is disabled is ignored.
- R6: The post-trigger counter drops by one for each stored word that was accepted in the trigger cycle or later. When it reaches 0, status bit 2 (complete) sets, no further word is stored, and the write pointer stops.
- R7: If the counter is 0 when the trigger arrives, status bit 2 sets at once. The word accepted in the trigger cycle is not stored.
- R8: Writing control with bit 0 = 0 stops capture and leaves status bits 0 to 2 unchanged. Writing bit 0 = 1 while capture is disabled clears status bits 0 to 2.
- R9: Status bit 3 (pipeline empty) reads 0 in the cycle after a word is accepted, while that word is still waiting to be written into RAM.
- R10: A read of the data register (address 4) returns the RAM word at the read pointer and then advances the pointer, wrapping at DEPTH. The read pointer (address 3) is writable and can be read back.
- R11: Control bit 1 (demultiplexed port mode) is stored and reads back. It has no effect on capture.
- R12: reg_rdata holds the last value read until the next read strobe.
- R13: A software write to the write pointer or counter takes priority over the hardware update in the same cycle. The word being written in that cycle still goes to the old pointer address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trc_vld | input | 1 | Trace word valid |
| trc_data | input | WORD_W | Trace word |
| trig_in | input | 1 | Trigger pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | WORD_W | Register write data |
| reg_rdata | output | WORD_W | Registered read data |

## Verification
Two pairs of events can land in the same cycle.

- A trigger pulse can coincide with an accepted trace word. The bench provokes this by driving trig_in together with trc_vld. With a counter of 4, it then reads the stored words back to show that the coincident word counts as the first post-trigger word. With a counter of 0, it shows that the coincident word is dropped and the write pointer does not move.
- A software write to the write pointer can coincide with the RAM write of a pending word. The bench drives both in one cycle and reads back the pointer and the word. The pointer must hold the software value, and the word must sit at the old address.

// File: rtl/trc_pkg.sv
package trc_pkg;

    localparam int REG_AW = 4;

    typedef enum logic [REG_AW-1:0] {
        RA_CTRL  = 4'd0,
        RA_STAT  = 4'd1,
        RA_WPTR  = 4'd2,
        RA_RPTR  = 4'd3,
        RA_DATA  = 4'd4,
        RA_TCNT  = 4'd5,
        RA_DEPTH = 4'd6,
        RA_WIDTH = 4'd7
    } reg_addr_e;

    // Control bit positions (software decodes these)
    localparam int CTL_EN  = 0;
    localparam int CTL_DMX = 1;

    // Status word: bit0 wrapped, bit1 triggered, bit2 complete, bit3 pipeline empty
    typedef struct packed {
        logic pipe_empty;
        logic acq_done;
        logic triggered;
        logic full;
    } stat_t;

endpackage

// File: rtl/trc_ram.sv
module trc_ram #(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/trc_acq.sv
module trc_acq
    import trc_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 32,
    parameter int CNT_W  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              arm,
    input  logic              trc_vld,
    input  logic [WORD_W-1:0] trc_data,
    input  logic              trig_in,
    input  logic              wptr_we,
    input  logic              cnt_we,
    input  logic [WORD_W-1:0] sw_wval,
    output logic              ram_we,
    output logic [AW-1:0]     ram_waddr,
    output logic [WORD_W-1:0] ram_wdata,
    output logic [AW-1:0]     wptr,
    output logic [CNT_W-1:0]  cnt,
    output stat_t             stat
);

    localparam logic [AW-1:0]    LAST = AW'(DEPTH - 1);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    typedef struct packed {
        logic              pend_vld;
        logic [WORD_W-1:0] pend_data;
        logic [AW-1:0]     wptr;
        logic [CNT_W-1:0]  cnt;
        logic              full;
        logic              trig;
        logic              done;
    } acq_t;

    acq_t s_d, s_q;
    logic accept, commit, trig_hit;

    // A word enters the pipeline stage only while capture is live
    assign accept   = en && !s_q.done && trc_vld;
    // The pending word is written unless acquisition has ended meanwhile
    assign commit   = s_q.pend_vld && !s_q.done;
    assign trig_hit = trig_in && en && !s_q.trig;

    always_comb begin
        s_d          = s_q;
        s_d.pend_vld = accept;
        if (accept) begin
            s_d.pend_data = trc_data;
        end

        if (commit) begin
            s_d.wptr = (s_q.wptr == LAST) ? '0 : s_q.wptr + AW'(1);
            if (s_q.wptr == LAST) begin
                s_d.full = 1'b1;
            end
        end

        if (trig_hit) begin
            s_d.trig = 1'b1;
            if (s_q.cnt == '0) begin
                s_d.done = 1'b1;
            end
        end else if (s_q.trig && commit && (s_q.cnt != '0)) begin
            s_d.cnt = s_q.cnt - ONE;
            if (s_q.cnt == ONE) begin
                s_d.done = 1'b1;
            end
        end

        if (arm) begin
            s_d.full = 1'b0;
            s_d.trig = 1'b0;
            s_d.done = 1'b0;
        end

        // Software writes take priority over hardware updates
        if (wptr_we) begin
            s_d.wptr = sw_wval[AW-1:0];
        end
        if (cnt_we) begin
            s_d.cnt = sw_wval[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ram_we          = commit;
    assign ram_waddr       = s_q.wptr;
    assign ram_wdata       = s_q.pend_data;
    assign wptr            = s_q.wptr;
    assign cnt             = s_q.cnt;
    assign stat.full       = s_q.full;
    assign stat.triggered  = s_q.trig;
    assign stat.acq_done   = s_q.done;
    assign stat.pipe_empty = !s_q.pend_vld;

endmodule

// File: rtl/trc_regs.sv
module trc_regs
    import trc_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 32,
    parameter int CNT_W  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              en,
    output logic              arm,
    output logic              wptr_we,
    output logic              cnt_we,
    output logic [WORD_W-1:0] sw_wval,
    input  logic [AW-1:0]     wptr,
    input  logic [CNT_W-1:0]  cnt,
    input  stat_t             stat,
    output logic [AW-1:0]     ram_raddr,
    input  logic [WORD_W-1:0] ram_rdata
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic              en;
        logic              dmx;
        logic [AW-1:0]     rptr;
        logic [WORD_W-1:0] rdata;
    } regs_t;

    regs_t s_d, s_q;
    logic  ctrl_wr, rptr_wr;
    logic [WORD_W-1:0] rd_mux;

    assign ctrl_wr = reg_wr && (reg_addr == RA_CTRL);
    assign rptr_wr = reg_wr && (reg_addr == RA_RPTR);
    assign wptr_we = reg_wr && (reg_addr == RA_WPTR);
    assign cnt_we  = reg_wr && (reg_addr == RA_TCNT);
    assign arm     = ctrl_wr && reg_wdata[CTL_EN] && !s_q.en;
    assign sw_wval = reg_wdata;

    always_comb begin
        case (reg_addr)
            RA_CTRL:  rd_mux = WORD_W'({s_q.dmx, s_q.en});
            RA_STAT:  rd_mux = WORD_W'(stat);
            RA_WPTR:  rd_mux = WORD_W'(wptr);
            RA_RPTR:  rd_mux = WORD_W'(s_q.rptr);
            RA_DATA:  rd_mux = ram_rdata;
            RA_TCNT:  rd_mux = WORD_W'(cnt);
            RA_DEPTH: rd_mux = WORD_W'(DEPTH);
            RA_WIDTH: rd_mux = WORD_W'(WORD_W);
            default:  rd_mux = '0;
        endcase
    end

    always_comb begin
        s_d = s_q;
        if (reg_rd) begin
            s_d.rdata = rd_mux;
            if (reg_addr == RA_DATA) begin
                s_d.rptr = (s_q.rptr == LAST) ? '0 : s_q.rptr + AW'(1);
            end
        end
        if (ctrl_wr) begin
            s_d.en  = reg_wdata[CTL_EN];
            s_d.dmx = reg_wdata[CTL_DMX];
        end
        if (rptr_wr) begin
            s_d.rptr = reg_wdata[AW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign en        = s_q.en;
    assign ram_raddr = s_q.rptr;
    assign reg_rdata = s_q.rdata;

endmodule

// File: rtl/trace_ring_capture.sv
module trace_ring_capture
    import trc_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 32,
    parameter int CNT_W  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trc_vld,
    input  logic [WORD_W-1:0] trc_data,
    input  logic              trig_in,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata
);

    logic              ctl_en, arm, wptr_we, cnt_we, ram_we;
    logic [WORD_W-1:0] sw_wval, ram_wdata, ram_rdata;
    logic [AW-1:0]     acq_wptr, ram_waddr, ram_raddr;
    logic [CNT_W-1:0]  acq_cnt;
    stat_t             stat;

    trc_regs #(.DEPTH(DEPTH), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .en        (ctl_en),
        .arm       (arm),
        .wptr_we   (wptr_we),
        .cnt_we    (cnt_we),
        .sw_wval   (sw_wval),
        .wptr      (acq_wptr),
        .cnt       (acq_cnt),
        .stat      (stat),
        .ram_raddr (ram_raddr),
        .ram_rdata (ram_rdata)
    );

    trc_acq #(.DEPTH(DEPTH), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_acq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctl_en),
        .arm       (arm),
        .trc_vld   (trc_vld),
        .trc_data  (trc_data),
        .trig_in   (trig_in),
        .wptr_we   (wptr_we),
        .cnt_we    (cnt_we),
        .sw_wval   (sw_wval),
        .ram_we    (ram_we),
        .ram_waddr (ram_waddr),
        .ram_wdata (ram_wdata),
        .wptr      (acq_wptr),
        .cnt       (acq_cnt),
        .stat      (stat)
    );

    trc_ram #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

endmodule

// File: rtl/trc_chk.sv
module trc_chk
    import trc_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              arm,
    input logic              ram_we,
    input logic [AW-1:0]     wptr,
    input logic [AW-1:0]     rptr,
    input stat_t             stat,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [REG_AW-1:0] reg_addr
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    // R4
    full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat.full && !arm) |=> stat.full);

    // R6
    no_write_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat.acq_done |-> !ram_we);

    // R6
    done_needs_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat.acq_done |-> stat.triggered);

    // R5
    trig_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat.triggered && !en) |=> !stat.triggered);

    // R3
    wptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && !(reg_wr && reg_addr == RA_WPTR))
        |=> wptr == (($past(wptr) == LAST) ? '0 : $past(wptr) + AW'(1)));

    // R10
    rptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == RA_DATA && !(reg_wr && reg_addr == RA_RPTR))
        |=> rptr == (($past(rptr) == LAST) ? '0 : $past(rptr) + AW'(1)));

endmodule

bind trace_ring_capture trc_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (ctl_en),
    .arm      (arm),
    .ram_we   (ram_we),
    .wptr     (acq_wptr),
    .rptr     (ram_raddr),
    .stat     (stat),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr)
);

// File: tb/test_trace_ring_capture.sv
module test_trace_ring_capture;
    import trc_pkg::*;

    localparam int DEPTH = 16;
    localparam int W     = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         trc_vld = 1'b0;
    logic [W-1:0] trc_data = '0;
    logic         trig_in = 1'b0;
    logic         reg_wr = 1'b0;
    logic         reg_rd = 1'b0;
    logic [3:0]   reg_addr = '0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [W-1:0] exp;
        string        tag;
    } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    trace_ring_capture #(.DEPTH(DEPTH), .WORD_W(W)) i_trace_ring_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .trc_vld   (trc_vld),
        .trc_data  (trc_data),
        .trig_in   (trig_in),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    // Driver tasks: start and end on a falling edge
    task automatic rd(input logic [3:0] a, input logic [W-1:0] e, input string tag);
        exp_t it;
        it.exp = e;
        it.tag = tag;
        exp_q.push_back(it);
        reg_rd   = 1'b1;
        reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic word(input logic [W-1:0] d, input logic t);
        trc_vld  = 1'b1;
        trc_data = d;
        trig_in  = t;
        @(negedge clk);
        trc_vld = 1'b0;
        trig_in = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic [W-1:0] act, input logic [W-1:0] e, input string tag);
        checks++;
        if (act !== e) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, e);
        end
    endtask

    // Monitor: read data is valid at the falling edge after the sampling edge
    initial begin
        forever begin
            @(posedge clk);
            if (reg_rd) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    checks++;
                    failures++;
                    $display("FAIL scoreboard empty actual=%h expected=none", reg_rdata);
                end else begin
                    exp_t it;
                    it = exp_q.pop_front();
                    chk(reg_rdata, it.exp, it.tag);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(RA_CTRL, 32'h0, "R1 ctrl");
        rd(RA_STAT, 32'h8, "R1 status");
        rd(RA_WPTR, 32'h0, "R1 wptr");
        rd(RA_RPTR, 32'h0, "R1 rptr");
        rd(RA_TCNT, 32'h0, "R1 tcnt");
        // R2 geometry
        rd(RA_DEPTH, DEPTH, "R2 depth");
        rd(RA_WIDTH, W, "R2 width");
        rd(4'hC, 32'h0, "R2 unmapped");

        // R3/R5: disabled capture ignores words and trigger
        for (int i = 0; i < 3; i++) word(32'hDEAD_0000 + i, (i == 1));
        idle(2);
        rd(RA_WPTR, 32'h0, "R3 disabled no store");
        rd(RA_STAT, 32'h8, "R5 trigger ignored when disabled");

        // Program and capture
        wr(RA_TCNT, 32'd4);
        wr(RA_WPTR, 32'd0);
        wr(RA_CTRL, 32'h1);
        for (int i = 0; i < 5; i++) word(32'h100 + i, 1'b0);
        word(32'h105, 1'b0);
        rd(RA_STAT, 32'h0, "R9 pipeline not empty");
        idle(2);
        rd(RA_WPTR, 32'd6, "R3 wptr advance");
        rd(RA_STAT, 32'h8, "R9 pipeline empty again");

        // R10 drain
        wr(RA_RPTR, 32'd0);
        rd(RA_DATA, 32'h100, "R10 data 0");
        rd(RA_DATA, 32'h101, "R10 data 1");
        rd(RA_RPTR, 32'd2, "R10 rptr advanced");
        idle(3);
        chk(reg_rdata, 32'd2, "R12 rdata held");

        // R6: trigger coincident with a word, counter 4
        word(32'h200, 1'b1);
        for (int i = 1; i < 6; i++) word(32'h200 + i, 1'b0);
        idle(2);
        rd(RA_WPTR, 32'd10, "R6 wptr stops after count");
        rd(RA_STAT, 32'hE, "R6 status trig+done+empty");
        rd(RA_TCNT, 32'd0, "R6 counter exhausted");
        wr(RA_RPTR, 32'd6);
        for (int i = 0; i < 4; i++) rd(RA_DATA, 32'h200 + i, "R6 post-trigger words");

        // R8 stop keeps flags, re-arm clears them
        wr(RA_CTRL, 32'h0);
        rd(RA_STAT, 32'hE, "R8 stop keeps flags");
        wr(RA_CTRL, 32'h1);
        rd(RA_STAT, 32'h8, "R8 re-arm clears flags");
        rd(RA_CTRL, 32'h1, "R8 ctrl enabled");

        // R11 mode bit
        wr(RA_CTRL, 32'h3);
        rd(RA_CTRL, 32'h3, "R11 mode bit readback");

        // R4 wrap
        wr(RA_WPTR, 32'd12);
        for (int i = 0; i < 6; i++) word(32'h300 + i, 1'b0);
        idle(2);
        rd(RA_WPTR, 32'd2, "R4 wptr wrapped");
        rd(RA_STAT, 32'h9, "R4 full set, R11 no effect");
        wr(RA_RPTR, 32'd15);
        rd(RA_DATA, 32'h303, "R10 data at last address");
        rd(RA_DATA, 32'h304, "R10 rptr wraps to 0");
        rd(RA_RPTR, 32'd1, "R10 rptr after wrap");

        // R7 zero count at trigger
        wr(RA_CTRL, 32'h0);
        wr(RA_CTRL, 32'h1);
        rd(RA_STAT, 32'h8, "R8 re-arm clears full");
        wr(RA_TCNT, 32'd0);
        word(32'h400, 1'b1);
        word(32'h401, 1'b0);
        idle(2);
        rd(RA_WPTR, 32'd2, "R7 nothing stored");
        rd(RA_STAT, 32'hE, "R7 immediate completion");
        wr(RA_RPTR, 32'd2);
        rd(RA_DATA, 32'h102, "R7 old word untouched");

        // R13 software pointer write during a RAM commit
        wr(RA_CTRL, 32'h0);
        wr(RA_CTRL, 32'h1);
        wr(RA_TCNT, 32'd8);
        trc_vld  = 1'b1;
        trc_data = 32'h500;
        @(negedge clk);
        trc_vld   = 1'b0;
        reg_wr    = 1'b1;
        reg_addr  = RA_WPTR;
        reg_wdata = 32'd7;
        @(negedge clk);
        reg_wr = 1'b0;
        idle(2);
        rd(RA_WPTR, 32'd7, "R13 software wptr wins");
        rd(RA_TCNT, 32'd8, "R13 counter written");
        wr(RA_RPTR, 32'd2);
        rd(RA_DATA, 32'h500, "R13 word at old address");

        idle(3);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule